// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block holds the receive and transmit error counters of a CAN node and derives from them the node's fault-confinement state. A bit-level protocol engine feeds it one-cycle strobes. The error strobes are bit, stuff, form, CRC and ACK. The success strobes mark a frame received or a frame sent. A sample-point strobe carries the sampled bus level. Qualifier inputs say whether the node is transmitting and whether it is sending an active error flag. Two further qualifiers mark the two situations in which a transmit error is excused.

After enable or a wake-up strobe, the node waits in a synchronization phase until it samples a run of recessive bits. It then takes part in the bus as error active, with a warning sub-state. Errors move it to error passive. A transmit counter that runs past 255 moves it to bus off, where the drivers are disabled. The node leaves bus off only after a long run of recessive sequences, and it then restarts with both counters cleared.

Top module: `can_fault_conf`

## Requirements
- R1: While reset is asserted or `enable` is low, both counters read 0, `sync` is 1, `state` is 2'b00 and `drv_en` is 0.
- R2: `sync` clears, and `drv_en` rises, once SYNC_BITS (11) recessive samples (`samp_en`=1, `samp_dom`=0) arrive with no dominant sample between them. A dominant sample restarts the count. A `wake` strobe returns the node to sync and keeps the counter values.
- R3: A receiver (`is_tx`=0) adds 8 to `rec` in two cases: on a bit error while `in_aflag`=1, and on `ev_first_dom`.
- R4: While receiving, a stuff, form, CRC or ACK error adds 1 to `rec`. While transmitting (`is_tx`=1), any error adds 8 to `tec`.
- R5: `ev_rx_ok` lowers `rec` by 1 and `ev_tx_ok` lowers `tec` by 1. A counter already at 0 stays at 0.
- R6: Once bit 7 of `rec` is set, `rec` no longer increments, although it can still decrement.
- R7: A transmitter stuff error with `arb_stuff`=1 leaves `tec` unchanged.
- R8: A transmitter ACK error with `ack_quiet`=1 leaves `tec` unchanged while the node is error passive. In error active, the same error still adds 8.
- R9: `warn` is 1 in error active when either counter is at least 96. It is 0 when both counters are below 96.
- R10: `state` reads 2'b01 (passive) when either counter exceeds 127, and 2'b00 (active) once both counters are at or below 127.
- R11: When `tec` exceeds 255, `state` reads 2'b10 (bus off) and `drv_en` is 0. Error and success strobes then change neither counter.
- R12: Bus off ends after RECOV_SEQS (128) sequences of 11 consecutive recessive samples. A dominant sample restarts only the current sequence. On exit, both counters become 0 and `state` reads 2'b00.
- R13: Error and success strobes change neither counter while `sync` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Node enable; low holds the node cleared and in sync |
| wake | input | 1 | Wake-up strobe; restarts synchronization |
| samp_en | input | 1 | Sample-point strobe |
| samp_dom | input | 1 | Sampled level, 1 = dominant |
| ev_bit_err | input | 1 | Bit error strobe |
| ev_stuff_err | input | 1 | Stuff error strobe |
| ev_form_err | input | 1 | Form error strobe |
| ev_crc_err | input | 1 | CRC error strobe |
| ev_ack_err | input | 1 | ACK error strobe |
| ev_rx_ok | input | 1 | Frame received correctly |
| ev_tx_ok | input | 1 | Frame sent correctly |
| ev_first_dom | input | 1 | Dominant first bit after an error flag |
| is_tx | input | 1 | Node is transmitter for this event |
| in_aflag | input | 1 | Node is sending an active error flag |
| arb_stuff | input | 1 | Stuff error on a recessive stuff bit during arbitration |
| ack_quiet | input | 1 | No dominant bit seen during the passive error flag |
| rec | output | 8 | Receive error counter |
| tec | output | 9 | Transmit error counter |
| state | output | 2 | 00 active, 01 passive, 10 bus off |
| warn | output | 1 | Error warning sub-state |
| sync | output | 1 | Synchronizing |
| drv_en | output | 1 | Bus driver enable |

## Verification
The counting rules are driven as one vector table. Receiver and transmitter roles are interleaved, so a role mix-up shows as a wrong counter. Error flag and first-dominant cases are set against ordinary errors, which separates the +8 rules from the +1 rule. Each exemption qualifier is tried both where it applies and where it must not. Directed runs then climb the counters through 95/96, 127/128 and 255/263, so that off-by-one thresholds show. They also break the sync and recovery runs with one dominant sample, which shows whether a dominant sample restarts the whole count or only the current sequence.

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int SYNC_BITS  = 11,
  parameter int RECOV_SEQS = 128,
  parameter int WARN_LIM   = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       wake,
  input  logic       samp_en,
  input  logic       samp_dom,
  input  logic       ev_bit_err,
  input  logic       ev_stuff_err,
  input  logic       ev_form_err,
  input  logic       ev_crc_err,
  input  logic       ev_ack_err,
  input  logic       ev_rx_ok,
  input  logic       ev_tx_ok,
  input  logic       ev_first_dom,
  input  logic       is_tx,
  input  logic       in_aflag,
  input  logic       arb_stuff,
  input  logic       ack_quiet,
  output logic [7:0] rec,
  output logic [8:0] tec,
  output logic [1:0] state,
  output logic       warn,
  output logic       sync,
  output logic       drv_en
);
  localparam int BW = (SYNC_BITS  > 1) ? $clog2(SYNC_BITS)  : 1;
  localparam int SW = (RECOV_SEQS > 1) ? $clog2(RECOV_SEQS) : 1;

  logic [BW-1:0] bitcnt;
  logic [SW-1:0] seqcnt;
  logic [7:0]    rec_nx;
  logic [8:0]    tec_nx;

  wire busoff   = tec[8];
  wire passive  = rec[7] | tec[7];
  wire any_err  = ev_bit_err | ev_stuff_err | ev_form_err | ev_crc_err | ev_ack_err;
  wire rx_big   = !is_tx && ((ev_bit_err && in_aflag) || ev_first_dom);
  wire rx_small = !is_tx && any_err;
  wire tx_hit   = is_tx && (ev_bit_err || ev_form_err || ev_crc_err ||
                            (ev_stuff_err && !arb_stuff) ||
                            (ev_ack_err && !(passive && ack_quiet)));
  wire bit_done = samp_en && !samp_dom && (bitcnt == BW'(SYNC_BITS - 1));

  always_comb begin
    rec_nx = rec;
    if (rx_big || rx_small) begin
      if (!rec[7]) rec_nx = rec + (rx_big ? 8'd8 : 8'd1);
    end else if (ev_rx_ok && rec != 8'd0) begin
      rec_nx = rec - 8'd1;
    end
    tec_nx = tec;
    if (tx_hit) tec_nx = tec + 9'd8;
    else if (ev_tx_ok && tec != 9'd0) tec_nx = tec - 9'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      rec    <= '0;
      tec    <= '0;
      sync   <= 1'b1;
      bitcnt <= '0;
      seqcnt <= '0;
    end else if (wake) begin
      sync   <= 1'b1;
      bitcnt <= '0;
      seqcnt <= '0;
    end else if (sync || busoff) begin
      if (samp_en) bitcnt <= (samp_dom || bit_done) ? '0 : bitcnt + 1'b1;
      if (bit_done) begin
        if (sync) sync <= 1'b0;
        else if (seqcnt == SW'(RECOV_SEQS - 1)) begin
          seqcnt <= '0;
          rec    <= '0;
          tec    <= '0;
        end else seqcnt <= seqcnt + 1'b1;
      end
    end else begin
      rec <= rec_nx;
      tec <= tec_nx;
    end
  end

  assign state  = busoff ? 2'b10 : passive ? 2'b01 : 2'b00;
  assign warn   = !busoff && !passive &&
                  (rec >= 8'(WARN_LIM) || tec >= 9'(WARN_LIM));
  assign drv_en = !sync && !busoff;

  p_sync_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync) |-> $past(samp_en && !samp_dom));
  p_sync_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && enable && !wake) |=> ($stable(rec) && $stable(tec)));
  p_rec_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec[7] |=> (rec <= $past(rec)));
  p_tec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tec[8] |=> ({1'b0, tec} <= {1'b0, $past(tec)} + 10'd8));
  p_busoff_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tec[8]) |-> (tec == 9'd0 && rec == 8'd0));
  p_busoff_drv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tec[8] && $past(tec[8]) && !$past(samp_en)) |-> ($stable(tec) && !drv_en));
endmodule

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
  logic clk = 0, rst_n = 0, enable = 1, wake = 0, samp_en = 0, samp_dom = 0;
  logic [11:0] stim = '0;
  logic [7:0] rec;
  logic [8:0] tec;
  logic [1:0] state;
  logic warn, sync, drv_en;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  can_fault_conf uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wake(wake),
    .samp_en(samp_en), .samp_dom(samp_dom),
    .ev_bit_err(stim[11]), .ev_stuff_err(stim[10]), .ev_form_err(stim[9]),
    .ev_crc_err(stim[8]), .ev_ack_err(stim[7]), .ev_rx_ok(stim[6]),
    .ev_tx_ok(stim[5]), .ev_first_dom(stim[4]), .is_tx(stim[3]),
    .in_aflag(stim[2]), .arb_stuff(stim[1]), .ack_quiet(stim[0]),
    .rec(rec), .tec(tec), .state(state), .warn(warn), .sync(sync), .drv_en(drv_en));

  localparam logic [11:0] BIT = 12'h800, STF = 12'h400, FRM = 12'h200, CRC = 12'h100,
    ACK = 12'h080, RXOK = 12'h040, TXOK = 12'h020, FDOM = 12'h010, TX = 12'h008,
    AFL = 12'h004, ARB = 12'h002, AQ = 12'h001;

  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {FRM,            8'd1,  9'd0},
    {CRC,            8'd2,  9'd0},
    {BIT | AFL,      8'd10, 9'd0},
    {FDOM,           8'd18, 9'd0},
    {RXOK,           8'd17, 9'd0},
    {STF | TX,       8'd17, 9'd8},
    {ACK | TX,       8'd17, 9'd16},
    {BIT | TX | AFL, 8'd17, 9'd24},
    {STF | TX | ARB, 8'd17, 9'd24},
    {ACK | TX | AQ,  8'd17, 9'd32},
    {TXOK,           8'd17, 9'd31},
    {ACK,            8'd18, 9'd31}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic ev(input logic [11:0] s);
    @(negedge clk) stim = s;
    @(negedge clk) stim = '0;
  endtask

  task automatic smp(input logic dom);
    @(negedge clk) begin samp_en = 1; samp_dom = dom; end
    @(negedge clk) samp_en = 0;
  endtask

  task automatic cnt(input string req, input int r, input int t);
    chk({req, " rec"}, rec, r);
    chk({req, " tec"}, tec, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sync", sync, 1); chk("R1 drv", drv_en, 0); chk("R1 state", state, 0);
    cnt("R1", 0, 0);
    rst_n = 1;
    repeat (10) smp(0);
    smp(1);
    ev(FRM | TX); ev(RXOK);
    cnt("R13", 0, 0);
    repeat (10) smp(0);
    chk("R2 still sync", sync, 1);
    smp(0);
    chk("R2 sync done", sync, 0); chk("R2 drv", drv_en, 1);
    ev(TXOK); ev(RXOK);
    cnt("R5 zero", 0, 0);

    for (int i = 0; i < NV; i++) begin
      ev(VEC[i][28:17]);
      cnt($sformatf("R3/R4/R5/R7/R8 vec%0d", i), VEC[i][16:9], VEC[i][8:0]);
    end

    repeat (8) ev(FRM | TX);
    chk("R9 95", warn, 0);
    ev(FRM | TX);
    chk("R9 103", warn, 1); chk("R9 state", state, 0);
    repeat (7) ev(TXOK);
    chk("R9 96", warn, 1);
    ev(TXOK);
    chk("R9 back 95", warn, 0);
    repeat (4) ev(FRM | TX);
    chk("R10 127 state", state, 0); chk("R9 127 warn", warn, 1);
    ev(FRM | TX);
    chk("R10 135 state", state, 1); chk("R9 passive warn", warn, 0);
    ev(ACK | TX | AQ);
    cnt("R8 passive quiet", 18, 135);
    ev(ACK | TX);
    cnt("R8 passive loud", 18, 143);
    repeat (16) ev(TXOK);
    chk("R10 return", state, 0);

    repeat (13) ev(FDOM);
    cnt("R3 climb", 122, 127);
    ev(FDOM);
    chk("R10 rec 130", state, 1);
    ev(FDOM); ev(FRM);
    cnt("R6 capped", 130, 127);
    ev(RXOK);
    cnt("R6 decr", 129, 127);

    repeat (16) ev(FRM | TX);
    chk("R11 255 state", state, 1);
    ev(FRM | TX);
    chk("R11 state", state, 2); chk("R11 drv", drv_en, 0);
    ev(FRM); ev(RXOK); ev(TXOK | FRM | TX);
    cnt("R11 frozen", 129, 263);

    for (int s = 0; s < 127; s++) repeat (11) smp(0);
    repeat (10) smp(0);
    smp(1);
    repeat (10) smp(0);
    chk("R12 not yet", state, 2);
    smp(0);
    chk("R12 state", state, 0); chk("R12 drv", drv_en, 1);
    cnt("R12", 0, 0);

    ev(FRM);
    @(negedge clk) wake = 1;
    @(negedge clk) wake = 0;
    chk("R2 wake sync", sync, 1); chk("R2 wake drv", drv_en, 0);
    cnt("R2 wake keep", 1, 0);
    repeat (11) smp(0);
    chk("R2 wake done", sync, 0);
    @(negedge clk) enable = 0;
    @(negedge clk) enable = 1;
    chk("R1 disable sync", sync, 1);
    cnt("R1 disable", 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule